// File: doc/BRIEF.md
# Dual-Port Pixel Output Demultiplexer

This block takes a stream of sampled 24-bit RGB pixels and spreads it over two 24-bit output ports, A and B. It also produces a data-clock toggle that marks each output period and a horizontal sync output aligned to the data. In single-port mode every pixel goes to port A and port B stays tri-stated. In dual-port mode, consecutive pixels alternate between the ports. The alternation restarts at each line marker, and the data clock runs at half the pixel rate.

Dual-port mode has two presentation styles. In interleaved presentation, each port takes its pixel one cycle after that pixel is accepted. In paired presentation, the A pixel waits in a holding register until its B partner arrives, and then both ports update together. A global output-disable input removes the drive enables of both ports. The sync output has a programmable polarity and a programmable width in pixel clocks. All outputs come from one register stage, so data, data clock and sync keep a fixed relationship to each other.

Top module: `pixel_port_demux`

## Requirements
- R1: After reset, both data ports read zero, both output enables are 0, the data-clock toggle is 0 and the sync output is at its inactive level (the inverse of `hs_pol`).
- R2: With `dual_en`=0, each accepted pixel appears on port A on the cycle after it is accepted. Port B data does not change, and `portb_oe` is 0.
- R3: With `dual_en`=1, the first pixel accepted with or after `hs_mark` belongs to port A, the next to port B, the next to A, and so on. A pixel accepted in the same cycle as `hs_mark` counts as the first.
- R4: With `dual_en`=1 and `par_mode`=0 (interleaved), a pixel appears on its own port one cycle after acceptance, and the other port keeps its value.
- R5: With `dual_en`=1 and `par_mode`=1 (paired), accepting an A-slot pixel changes neither port. Accepting the following B-slot pixel updates port A with the held pixel and port B with the new pixel on the same cycle.
- R6: In paired mode, an A-slot pixel that has no partner when `hs_mark` arrives is dropped and never reaches a port.
- R7: `dclk_tog` inverts once for every accepted pixel in single-port mode, and once for every accepted B-slot pixel in dual-port mode. It holds its value otherwise.
- R8: When `hs_mark` is seen, `hs_out` takes the level of `hs_pol` from the next cycle on, for exactly `hs_width` cycles, and then returns to the inverse level. A width of 0 gives no pulse. A new marker restarts the count.
- R9: `porta_oe` is the inverse of `out_dis`, and `portb_oe` is (not `out_dis`) and `dual_en`, both registered one cycle. Pixels still update the data registers while the outputs are disabled.
- R10: In a cycle without `pix_vld`, neither port's data nor `dclk_tog` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pix_vld | input | 1 | Pixel accepted this cycle |
| pix_data | input | 24 | Sampled RGB pixel |
| hs_mark | input | 1 | Line start marker; restarts alternation and sync pulse |
| dual_en | input | 1 | 1: two-port output, 0: port A only |
| par_mode | input | 1 | In dual mode, 1: paired, 0: interleaved |
| out_dis | input | 1 | Removes drive from both ports |
| hs_pol | input | 1 | Active level of `hs_out` |
| hs_width | input | 8 | Sync output width in pixel clocks |
| porta_data | output | 24 | Port A pixel |
| portb_data | output | 24 | Port B pixel |
| porta_oe | output | 1 | Port A drive enable |
| portb_oe | output | 1 | Port B drive enable |
| dclk_tog | output | 1 | Data clock, inverts once per output period |
| hs_out | output | 1 | Aligned horizontal sync output |

## Verification
Each result is due in the cycle right after the edge that accepts the pixel, marker or disable request: port data, output enables and the clock toggle all pass through a single register. The bench changes inputs on the falling edge and reads outputs on the next falling edge, which is half a cycle after the capturing rising edge. The sync pulse is checked cycle by cycle from that same first falling edge for `hs_width` cycles, and then on the cycle it must drop. Checks of things that must hold still (R5, R10) compare the ports with their earlier values after cycles with no pixel, or with a lone A-slot pixel.

// File: rtl/pixel_port_demux.sv
module pixel_port_demux #(
  parameter int PIX_W = 24,
  parameter int HW_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_vld,
  input  logic [PIX_W-1:0] pix_data,
  input  logic             hs_mark,
  input  logic             dual_en,
  input  logic             par_mode,
  input  logic             out_dis,
  input  logic             hs_pol,
  input  logic [HW_W-1:0]  hs_width,
  output logic [PIX_W-1:0] porta_data,
  output logic [PIX_W-1:0] portb_data,
  output logic             porta_oe,
  output logic             portb_oe,
  output logic             dclk_tog,
  output logic             hs_out
);

  localparam logic [HW_W-1:0] CNT_ONE = HW_W'(1);

  logic             sel_b;
  logic [PIX_W-1:0] hold_a;
  logic [HW_W-1:0]  hs_cnt;

  wire to_b = dual_en && sel_b && !hs_mark;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      porta_data <= '0;
      portb_data <= '0;
      hold_a     <= '0;
      sel_b      <= 1'b0;
      dclk_tog   <= 1'b0;
      porta_oe   <= 1'b0;
      portb_oe   <= 1'b0;
    end else begin
      porta_oe <= !out_dis;
      portb_oe <= !out_dis && dual_en;
      if (pix_vld) begin
        if (!dual_en) begin
          porta_data <= pix_data;
          dclk_tog   <= !dclk_tog;
          sel_b      <= 1'b0;
        end else if (!to_b) begin
          sel_b <= 1'b1;
          if (par_mode) hold_a     <= pix_data;
          else          porta_data <= pix_data;
        end else begin
          sel_b      <= 1'b0;
          dclk_tog   <= !dclk_tog;
          portb_data <= pix_data;
          if (par_mode) porta_data <= hold_a;
        end
      end else if (hs_mark) begin
        sel_b <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              hs_cnt <= '0;
    else if (hs_mark)        hs_cnt <= hs_width;
    else if (hs_cnt != '0)   hs_cnt <= hs_cnt - CNT_ONE;
  end

  assign hs_out = (hs_cnt != '0) ? hs_pol : !hs_pol;

  a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_vld |=> $stable(porta_data) && $stable(portb_data) && $stable(dclk_tog));

  a_r9_disable: assert property (@(posedge clk) disable iff (!rst_n)
    out_dis |=> !porta_oe && !portb_oe);

  a_r2_single_b_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !dual_en |=> $stable(portb_data));

  a_r2_single_a_data: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_vld && !dual_en) |=> porta_data == $past(pix_data));

  a_r7_single_clk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_vld && !dual_en) |=> dclk_tog != $past(dclk_tog));

  a_r3_mark_to_a: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_vld && hs_mark && dual_en) |=> $stable(portb_data) && $stable(dclk_tog));

  a_r8_hs_start: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_mark && hs_width != '0) |=> hs_out == hs_pol);

  a_r8_hs_end: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_cnt == CNT_ONE && !hs_mark) |=> hs_out == !hs_pol);

endmodule

// File: tb/test_pixel_port_demux.sv
module test_pixel_port_demux;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_vld = 1'b0;
  logic [23:0] pix_data = '0;
  logic        hs_mark = 1'b0;
  logic        dual_en = 1'b0;
  logic        par_mode = 1'b0;
  logic        out_dis = 1'b0;
  logic        hs_pol = 1'b1;
  logic [7:0]  hs_width = 8'd0;
  logic [23:0] porta_data, portb_data;
  logic        porta_oe, portb_oe, dclk_tog, hs_out;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  pixel_port_demux i_pixel_port_demux (
    .clk(clk), .rst_n(rst_n), .pix_vld(pix_vld), .pix_data(pix_data),
    .hs_mark(hs_mark), .dual_en(dual_en), .par_mode(par_mode),
    .out_dis(out_dis), .hs_pol(hs_pol), .hs_width(hs_width),
    .porta_data(porta_data), .portb_data(portb_data),
    .porta_oe(porta_oe), .portb_oe(portb_oe),
    .dclk_tog(dclk_tog), .hs_out(hs_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic push(input logic [23:0] px, input logic mark);
    pix_vld = 1'b1; pix_data = px; hs_mark = mark;
    @(negedge clk);
    pix_vld = 1'b0; hs_mark = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 porta", {8'h0, porta_data}, 32'h0);
    check("R1 portb", {8'h0, portb_data}, 32'h0);
    check("R1 oe", {30'h0, porta_oe, portb_oe}, 32'h0);
    check("R1 dclk", {31'h0, dclk_tog}, 32'h0);
    check("R1 hs_out", {31'h0, hs_out}, 32'h0);
  endtask

  task automatic t_single;
    logic d0;
    dual_en = 1'b0; out_dis = 1'b0;
    d0 = dclk_tog;
    push(24'h112233, 1'b0);
    check("R2 porta p1", {8'h0, porta_data}, 32'h112233);
    check("R2 portb quiet", {8'h0, portb_data}, 32'h0);
    check("R2 oe", {30'h0, porta_oe, portb_oe}, 32'h2);
    check("R7 single toggle 1", {31'h0, dclk_tog}, {31'h0, ~d0});
    push(24'h445566, 1'b1);
    check("R2 porta p2", {8'h0, porta_data}, 32'h445566);
    check("R7 single toggle 2", {31'h0, dclk_tog}, {31'h0, d0});
  endtask

  task automatic t_interleave;
    logic d0;
    logic [23:0] b0;
    dual_en = 1'b1; par_mode = 1'b0;
    @(negedge clk);
    b0 = portb_data; d0 = dclk_tog;
    check("R9 portb_oe dual", {31'h0, portb_oe}, 32'h1);
    push(24'hA00001, 1'b1);
    check("R3 first to A", {8'h0, porta_data}, 32'hA00001);
    check("R4 B holds", {8'h0, portb_data}, {8'h0, b0});
    check("R7 no toggle on A", {31'h0, dclk_tog}, {31'h0, d0});
    push(24'hB00001, 1'b0);
    check("R3 second to B", {8'h0, portb_data}, 32'hB00001);
    check("R4 A holds", {8'h0, porta_data}, 32'hA00001);
    check("R7 toggle on B", {31'h0, dclk_tog}, {31'h0, ~d0});
    push(24'hA00002, 1'b0);
    check("R3 third to A", {8'h0, porta_data}, 32'hA00002);
    push(24'hC00003, 1'b1);
    check("R3 mark restarts on A", {8'h0, porta_data}, 32'hC00003);
    check("R3 B untouched", {8'h0, portb_data}, 32'hB00001);
  endtask

  task automatic t_parallel;
    dual_en = 1'b1; par_mode = 1'b1;
    push(24'h0A0A01, 1'b1);
    check("R5 lone A porta", {8'h0, porta_data}, 32'hC00003);
    check("R5 lone A portb", {8'h0, portb_data}, 32'hB00001);
    push(24'h0B0B01, 1'b0);
    check("R5 pair porta", {8'h0, porta_data}, 32'h0A0A01);
    check("R5 pair portb", {8'h0, portb_data}, 32'h0B0B01);
    push(24'h0A0A02, 1'b0);
    push(24'h0C0C03, 1'b1);
    check("R6 dropped A porta", {8'h0, porta_data}, 32'h0A0A01);
    check("R6 dropped A portb", {8'h0, portb_data}, 32'h0B0B01);
    push(24'h0D0D04, 1'b0);
    check("R6 new pair porta", {8'h0, porta_data}, 32'h0C0C03);
    check("R6 new pair portb", {8'h0, portb_data}, 32'h0D0D04);
  endtask

  task automatic t_idle;
    logic d0;
    d0 = dclk_tog;
    repeat (4) @(negedge clk);
    check("R10 idle porta", {8'h0, porta_data}, 32'h0C0C03);
    check("R10 idle portb", {8'h0, portb_data}, 32'h0D0D04);
    check("R10 idle dclk", {31'h0, dclk_tog}, {31'h0, d0});
  endtask

  task automatic t_disable;
    dual_en = 1'b0; out_dis = 1'b1;
    @(negedge clk);
    check("R9 both off", {30'h0, porta_oe, portb_oe}, 32'h0);
    push(24'h5A5A5A, 1'b0);
    check("R9 data tracked", {8'h0, porta_data}, 32'h5A5A5A);
    out_dis = 1'b0;
    @(negedge clk);
    check("R9 A back on", {30'h0, porta_oe, portb_oe}, 32'h2);
  endtask

  task automatic hs_run(input logic pol, input logic [7:0] w);
    hs_pol = pol; hs_width = w;
    @(negedge clk);
    check("R8 idle level", {31'h0, hs_out}, {31'h0, ~pol});
    hs_mark = 1'b1;
    @(negedge clk);
    hs_mark = 1'b0;
    for (int i = 0; i < w; i++) begin
      check("R8 active", {31'h0, hs_out}, {31'h0, pol});
      @(negedge clk);
    end
    check("R8 ended", {31'h0, hs_out}, {31'h0, ~pol});
  endtask

  task automatic t_hsout;
    hs_run(1'b1, 8'd3);
    hs_run(1'b0, 8'd2);
    hs_run(1'b1, 8'd0);
    hs_pol = 1'b1;
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_single();
    t_interleave();
    t_parallel();
    t_idle();
    t_disable();
    t_hsout();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule